// File: doc/BRIEF.md
# Watchdog Timer with Strap-Qualified Start and Sticky Run Latch

This block is a watchdog timer for a small controller. A down counter is fed by a prescaled tick input. Each time the counter is loaded, its upper bits take a software-written reload value and its lower bits are set to all ones. When the count passes zero on a tick, the block raises a one-clock watchdog-reset pulse and the counter starts a new period. Software keeps the system alive by strobing `refresh`, which loads the counter again from the reload register.

There are two ways to start counting. In the first, the `strap_pin` level is captured while the external reset `hw_rst_n` is held low. If the captured level is high, counting begins as soon as reset is released, and `save_inhibit` is driven to block the power-saving modes. In the second, software writes a start bit, so the reload value can be programmed before the first period. Once running, the timer stays running. Software cannot stop it, and neither can its own watchdog reset. Only an external reset taken with the strap pin low stops it, or the power-on reset `por_n`, which starts the whole block from zero.

All pins are plain control and status signals. The block has no streaming data path and no handshake. A write is accepted in the cycle in which `wr_en` is high.

Top module: `wdog_core`

## Requirements
- R1: After `por_n` is asserted, `wdt_rst`, `running` and `save_inhibit` are 0. Ticks then produce no `wdt_rst` pulse until a start occurs.
- R2: A write with `wr_sel`=1 and `wr_data[0]`=1, made while stopped, sets `running` at that clock edge and loads the counter from the reload register. The first `wdt_rst` pulse then follows the (reload+1)·2^FINE_W-th tick.
- R3: `wdt_rst` rises in the cycle after the expiring tick and is high for exactly one clock.
- R4: A watchdog expiry clears the reload register to 0 and leaves `running` at 1. The next period is therefore 2^FINE_W ticks.
- R5: A write with `wr_sel`=0 stores `wr_data[RELOAD_W-1:0]` in the reload register at any time, whether the timer is running or stopped. The value is used at the next load.
- R6: `refresh` while running reloads the counter from the reload register and leaves `running` unchanged.
- R7: If `strap_pin` is high during the last cycle of an external reset (`hw_rst_n`=0), `running` becomes 1 at the first clock edge after release. The timer then runs with the default period of 2^FINE_W ticks until software changes the reload value.
- R8: A rising edge on `strap_pin` while `hw_rst_n` is high does not start the timer.
- R9: `save_inhibit` equals the `strap_pin` level captured during the most recent external reset, and it holds that value until the next one.
- R10: While running, a start-control write with `wr_data[0]`=0 is ignored. An external reset with `strap_pin` low clears `running`. An external reset with `strap_pin` high does not.
- R11: A one-cycle `pd_rst` clears the reload register and changes neither `running` nor the current count.
- R12: While stopped, the counter holds its value and no `wdt_rst` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| hw_rst_n | input | 1 | External hardware reset level, active low, sampled on the clock |
| pd_rst | input | 1 | Hardware power-down reset pulse; clears the reload register |
| strap_pin | input | 1 | Start/power-save strap, sampled only while `hw_rst_n` is low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = reload register, 1 = start control (bit 0 = start) |
| wr_data | input | WR_W | Write data |
| refresh | input | 1 | Reload the counter while running |
| tick | input | 1 | Prescaled count enable |
| wdt_rst | output | 1 | One-clock watchdog reset pulse |
| running | output | 1 | Run latch state |
| save_inhibit | output | 1 | Blocks the power-saving modes |

## Verification
The bench toggles the strap pin after reset is released and checks that the timer stays stopped. A design that sampled the pin at all times would start counting there and later fire a reset nobody asked for. The bench also runs through several watchdog expiries and software clear attempts while checking the run latch. A latch cleared by either would let a hung system escape supervision. It measures the period in ticks after a software start, a hardware start, a refresh, a power-down reset and a reload rewrite. An off-by-one in the load value, a missing clear on expiry, or a refresh that also alters the run state would each shift the measured count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    SEL_RELOAD = 1'b0,
    SEL_CTRL   = 1'b1
  } wdog_sel_e;

  localparam int CTRL_START_BIT = 0;
endpackage

// File: rtl/wdog_strap.sv
module wdog_strap (
  input  logic clk,
  input  logic por_n,
  input  logic rst_active,
  input  logic strap,
  output logic strap_q,
  output logic hw_start
);
  logic rst_prev_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      strap_q    <= 1'b0;
      rst_prev_q <= 1'b0;
    end else begin
      rst_prev_q <= rst_active;
      if (rst_active) strap_q <= strap;
    end
  end

  assign hw_start = rst_prev_q & ~rst_active & strap_q;

  // R9: captured level is frozen outside reset
  a_r9_strap_frozen: assert property (@(posedge clk) disable iff (!por_n)
    !rst_active |=> $stable(strap_q));
endmodule

// File: rtl/wdog_runlatch.sv
module wdog_runlatch (
  input  logic clk,
  input  logic por_n,
  input  logic rst_active,
  input  logic strap,
  input  logic hw_start,
  input  logic sw_start,
  output logic run_q
);
  logic stop_req;
  assign stop_req = rst_active & ~strap;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   run_q <= 1'b0;
    else if (stop_req)            run_q <= 1'b0;
    else if (hw_start | sw_start) run_q <= 1'b1;
  end

  // R10: only a strap-low external reset clears the latch
  a_r10_run_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (run_q && !(rst_active && !strap)) |=> run_q);
  // R8: no start without a start source
  a_r8_no_spurious_start: assert property (@(posedge clk) disable iff (!por_n)
    (!run_q && !hw_start && !sw_start) |=> !run_q);
endmodule

// File: rtl/wdog_reload.sv
module wdog_reload #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                clr,
  input  logic                wr,
  input  logic [RELOAD_W-1:0] wr_val,
  output logic [RELOAD_W-1:0] reload_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   reload_q <= '0;
    else if (clr) reload_q <= '0;
    else if (wr)  reload_q <= wr_val;
  end

  // R4/R11: any reset source empties the register
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (reload_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int RELOAD_W = 7,
  parameter int FINE_W   = 8
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_active,
  input  logic                run,
  input  logic                load_req,
  input  logic                tick,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expire
);
  localparam int CNT_W = RELOAD_W + FINE_W;
  localparam logic [CNT_W-1:0] BASE_VAL = {{RELOAD_W{1'b0}}, {FINE_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = {reload, {FINE_W{1'b1}}};
  assign expire   = run & ~rst_active & ~load_req & tick & (cnt_q == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              cnt_q <= BASE_VAL;
    else if (rst_active)     cnt_q <= BASE_VAL;
    else if (load_req)       cnt_q <= load_val;
    else if (expire)         cnt_q <= BASE_VAL;
    else if (run && tick)    cnt_q <= cnt_q - 1'b1;
  end

  // R12: a stopped counter holds
  a_r12_halt_when_stopped: assert property (@(posedge clk) disable iff (!por_n)
    (!run && !load_req && !rst_active) |=> $stable(cnt_q));
  // R6: a load takes the reload value
  a_r6_load_value: assert property (@(posedge clk) disable iff (!por_n)
    (load_req && !rst_active) |=> (cnt_q[FINE_W-1:0] == {FINE_W{1'b1}}));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int RELOAD_W = 7,
  parameter int FINE_W   = 8,
  parameter int WR_W     = 8
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            hw_rst_n,
  input  logic            pd_rst,
  input  logic            strap_pin,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [WR_W-1:0] wr_data,
  input  logic            refresh,
  input  logic            tick,
  output logic            wdt_rst,
  output logic            running,
  output logic            save_inhibit
);
  import wdog_pkg::*;

  logic rst_active, hw_start, sw_start, wr_reload, load_req, expire, run_q;
  logic [RELOAD_W-1:0] reload_q;
  logic wdt_rst_q;
  logic unused_wr_bits;

  assign rst_active     = ~hw_rst_n;
  assign sw_start       = wr_en & (wr_sel == SEL_CTRL) & wr_data[CTRL_START_BIT] & ~rst_active;
  assign wr_reload      = wr_en & (wr_sel == SEL_RELOAD) & ~rst_active;
  assign load_req       = hw_start | (sw_start & ~run_q) | (refresh & run_q);
  assign unused_wr_bits = ^wr_data;

  wdog_strap u_strap (
    .clk(clk), .por_n(por_n), .rst_active(rst_active), .strap(strap_pin),
    .strap_q(save_inhibit), .hw_start(hw_start)
  );

  wdog_runlatch u_run (
    .clk(clk), .por_n(por_n), .rst_active(rst_active), .strap(strap_pin),
    .hw_start(hw_start), .sw_start(sw_start), .run_q(run_q)
  );

  wdog_reload #(.RELOAD_W(RELOAD_W)) u_reload (
    .clk(clk), .por_n(por_n), .clr(rst_active | pd_rst | expire),
    .wr(wr_reload), .wr_val(wr_data[RELOAD_W-1:0]), .reload_q(reload_q)
  );

  wdog_counter #(.RELOAD_W(RELOAD_W), .FINE_W(FINE_W)) u_cnt (
    .clk(clk), .por_n(por_n), .rst_active(rst_active), .run(run_q),
    .load_req(load_req), .tick(tick), .reload(reload_q), .expire(expire)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wdt_rst_q <= 1'b0;
    else        wdt_rst_q <= expire;
  end

  assign wdt_rst = wdt_rst_q;
  assign running = run_q;

  // R3: pulse is one clock wide
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst |=> !wdt_rst);
  // R4: own reset leaves the latch set
  a_r4_run_survives: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst |-> running);
  // R1/R12: no pulse unless running in the previous cycle
  a_r12_no_pulse_stopped: assert property (@(posedge clk) disable iff (!por_n)
    !running |=> !wdt_rst);
  // R9: inhibit only moves during external reset
  a_r9_inhibit_hold: assert property (@(posedge clk) disable iff (!por_n)
    hw_rst_n |=> $stable(save_inhibit));
endmodule

// File: tb/sim_wdog_core.sv
module sim_wdog_core;
  localparam int RW = 7;
  localparam int FW = 2;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic por_n, hw_rst_n, pd_rst, strap_pin, wr_en, wr_sel, refresh, tick;
  logic [WW-1:0] wr_data;
  logic wdt_rst, running, save_inhibit;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  wdog_core #(.RELOAD_W(RW), .FINE_W(FW), .WR_W(WW)) u0 (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .pd_rst(pd_rst),
    .strap_pin(strap_pin), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .refresh(refresh), .tick(tick), .wdt_rst(wdt_rst), .running(running),
    .save_inhibit(save_inhibit)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = WW'(val);
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // returns tick number of the first pulse (0 if none), and checks pulse width
  task automatic measure(input int limit, output int n);
    n = 0;
    tick = 1'b1;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (wdt_rst) begin n = i; break; end
    end
    tick = 1'b0;
    if (n != 0) begin
      step();
      chk(wdt_rst == 1'b0, "R3 pulse width", int'(wdt_rst), 0);
    end
  endtask

  task automatic ext_reset(input logic strap_lvl, input int len);
    strap_pin = strap_lvl; hw_rst_n = 1'b0;
    for (int i = 0; i < len; i++) step();
  endtask

  task automatic t_por();
    int n;
    chk(!wdt_rst && !running && !save_inhibit, "R1 reset state",
        int'({wdt_rst, running, save_inhibit}), 0);
    measure(30, n);
    chk(n == 0, "R1 no pulse before start", n, 0);
  endtask

  task automatic t_strap_low_reset();
    int n;
    ext_reset(1'b0, 3);
    hw_rst_n = 1'b1; step();
    chk(!running && !save_inhibit, "R10 strap-low reset stopped",
        int'({running, save_inhibit}), 0);
    measure(40, n);
    chk(n == 0, "R12 no pulse while stopped", n, 0);
  endtask

  task automatic t_late_strap_edge();
    strap_pin = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk(running == 1'b0, "R8 post-reset strap edge", int'(running), 0);
    chk(save_inhibit == 1'b0, "R9 inhibit unchanged by late edge", int'(save_inhibit), 0);
    strap_pin = 1'b0; step();
  endtask

  task automatic t_sw_start();
    int n;
    wr(1'b0, 2);
    chk(running == 1'b0, "R5 reload write while stopped", int'(running), 0);
    wr(1'b1, 1);
    chk(running == 1'b1, "R2 software start", int'(running), 1);
    measure(60, n);
    chk(n == 12, "R2 first period (2+1)*4", n, 12);
    chk(running == 1'b1, "R4 run after watchdog reset", int'(running), 1);
    measure(60, n);
    chk(n == 4, "R4 reload cleared by expiry", n, 4);
  endtask

  task automatic t_sw_clear();
    wr(1'b1, 0);
    chk(running == 1'b1, "R10 software clear ignored", int'(running), 1);
  endtask

  task automatic t_refresh();
    int n;
    wr(1'b0, 1);
    tick = 1'b1; step(); step(); tick = 1'b0;
    refresh = 1'b1; step(); refresh = 1'b0;
    chk(running == 1'b1, "R6 refresh keeps running", int'(running), 1);
    measure(60, n);
    chk(n == 8, "R5 R6 period after refresh", n, 8);
  endtask

  task automatic t_pd_reset();
    int n;
    wr(1'b0, 5);
    pd_rst = 1'b1; step(); pd_rst = 1'b0;
    chk(running == 1'b1, "R11 power-down reset keeps running", int'(running), 1);
    refresh = 1'b1; step(); refresh = 1'b0;
    measure(60, n);
    chk(n == 4, "R11 reload cleared", n, 4);
  endtask

  task automatic t_hw_start();
    int n;
    ext_reset(1'b0, 2);
    chk(running == 1'b0, "R10 stop during strap-low reset", int'(running), 0);
    ext_reset(1'b1, 3);
    chk(save_inhibit == 1'b1, "R9 inhibit during reset", int'(save_inhibit), 1);
    chk(running == 1'b0, "R7 not running before release", int'(running), 0);
    hw_rst_n = 1'b1; step();
    chk(running == 1'b1, "R7 hardware start on release", int'(running), 1);
    strap_pin = 1'b0; step(); step();
    chk(save_inhibit == 1'b1, "R9 inhibit held", int'(save_inhibit), 1);
    measure(60, n);
    chk(n == 4, "R7 default period", n, 4);
    wr(1'b0, 2);
    refresh = 1'b1; step(); refresh = 1'b0;
    measure(60, n);
    chk(n == 12, "R7 reload overwrite after hardware start", n, 12);
    ext_reset(1'b1, 2);
    chk(running == 1'b1, "R10 strap-high reset keeps running", int'(running), 1);
    hw_rst_n = 1'b1; step();
    chk(running == 1'b1, "R10 running after strap-high reset", int'(running), 1);
    ext_reset(1'b0, 2);
    hw_rst_n = 1'b1; step();
    chk(!running && !save_inhibit, "R9 R10 strap-low reset clears",
        int'({running, save_inhibit}), 0);
  endtask

  initial begin
    por_n = 1'b0; hw_rst_n = 1'b1; pd_rst = 1'b0; strap_pin = 1'b0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; refresh = 1'b0; tick = 1'b0;
    step(); step();
    por_n = 1'b1;
    step();
    t_por();
    t_strap_low_reset();
    t_late_strap_edge();
    t_sw_start();
    t_sw_clear();
    t_refresh();
    t_pd_reset();
    t_hw_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule